// File: doc/BRIEF.md
# Dual-Limit Window Watchdog Comparator

This block watches a stream of reduced-resolution signed samples, 8 magnitude bits plus a sign, and compares each one against two programmable limits. It first subtracts an offset correction coefficient from the sample and clamps the result to the 9-bit signed range. The corrected value then goes to two strict comparators.

Each limit word holds three things: a magnitude, a sign, and a direction flag. The direction flag arms the limit for samples above it or for samples below it. When a sample lands on the armed side of a limit, that limit's status bit is set and stays set until software clears it with a write-one-to-clear pulse. The two status bits are ORed into a single interrupt. Arming limit A "above" a low value and limit B "below" a high value flags samples inside a window. Swapping both directions flags samples outside it.

A two-state machine controls the evaluation:
- **ST_IDLE** waits for a sample. The transition **IDLE→CMP** happens on a valid strobe, and the corrected sample is registered on that edge.
- **ST_CMP** applies the comparator results to the status bits. It takes **CMP→CMP** when another valid sample arrives, so back-to-back samples keep full throughput. It takes **CMP→IDLE** otherwise.

Top module: `wdg_window_top`

## Requirements
- R1: After reset, both status bits and the interrupt are 0.
- R2: A limit word is `{dir, sign, mag[7:0]}`. Bit 9 is the direction (1 = fire when the sample is above the limit, 0 = fire when it is below). Bit 8 is the sign (1 = negative). Bits 7:0 are the magnitude. The limit value is the signed number sign·mag.
- R3: The "above" test is strict. A corrected sample equal to the limit does not fire.
- R4: The "below" test is strict. A corrected sample equal to the limit does not fire.
- R5: The value compared is the sample minus the offset coefficient. Both are 9-bit two's complement.
- R6: The subtraction saturates. Results above 255 become 255, and results below −256 become −256.
- R7: A set status bit stays set while later samples do not fire its limit.
- R8: `stat_clr[0]` clears status bit 0 (limit A), and `stat_clr[1]` clears bit 1 (limit B), each independently. If a fire and a clear hit the same bit on the same edge, the bit ends up set.
- R9: `irq` is high exactly when at least one status bit is set.
- R10: A sample is accepted on the edge where `smp_valid` is high. Its status effect appears on the following edge.
- R11: A limit with sign 1 and magnitude 0 behaves as the value zero.
- R12: Sample data presented while `smp_valid` is low has no effect on the status.
- R13: In window mode (A above −20, B below +20), a sample inside the window sets both bits. With both directions swapped, a sample inside the window sets neither.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 9 | Signed sample, two's complement |
| ofs_coef | input | 9 | Signed offset correction coefficient |
| lim_a_word | input | 10 | Limit A word {dir, sign, mag} |
| lim_b_word | input | 10 | Limit B word {dir, sign, mag} |
| stat_clr | input | 2 | Write-one-to-clear pulse per status bit |
| stat_hit | output | 2 | Sticky status bits: bit 0 for limit A, bit 1 for limit B |
| irq | output | 1 | OR of the status bits |

## Verification
The bench goes after these corner cases:
- **Samples equal to the limit.** A non-strict compare would raise a status bit on these samples.
- **Negative-zero limits.** A faulty sign conversion would turn negative zero into a large negative bound.
- **Offset subtraction that overflows in both directions.** Without the clamp, the result wraps to the opposite sign and fires the wrong limit.
- **Per-bit clears and a clear that coincides with a fire.** A shared clear, or one that wins over the fire, would lose the event.
- **A sample held while the strobe is low.** A design that ignores the strobe would set status.
- **The cycle between acceptance and status update.** This catches a design whose latency is one edge off.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CMP  = 1'b1
    } wdg_state_t;
endpackage

// File: rtl/wdg_offset_sat.sv
module wdg_offset_sat #(
    parameter int W = 9
) (
    input  logic signed [W-1:0] raw_val,
    input  logic signed [W-1:0] ofs_val,
    output logic signed [W-1:0] cor_val
);
    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] wide_diff;

    always_comb begin
        wide_diff = {raw_val[W-1], raw_val} - {ofs_val[W-1], ofs_val};
        if (wide_diff[W] != wide_diff[W-1]) begin
            cor_val = wide_diff[W] ? MIN_V : MAX_V;
        end else begin
            cor_val = wide_diff[W-1:0];
        end
    end
endmodule

// File: rtl/wdg_limit_cmp.sv
module wdg_limit_cmp #(
    parameter int MAG_W = 8
) (
    input  logic signed [MAG_W:0]   cor_smp,
    input  logic        [MAG_W+1:0] lim_word,
    output logic                    fire
);
    localparam int SW = MAG_W + 1;

    logic              dir_above;
    logic              lim_neg;
    logic signed [SW-1:0] lim_mag;
    logic signed [SW-1:0] lim_val;

    always_comb begin
        dir_above = lim_word[MAG_W+1];
        lim_neg   = lim_word[MAG_W];
        lim_mag   = {1'b0, lim_word[MAG_W-1:0]};
        lim_val   = lim_neg ? -lim_mag : lim_mag;
        fire      = dir_above ? (cor_smp > lim_val) : (cor_smp < lim_val);
    end
endmodule

// File: rtl/wdg_window_top.sv
module wdg_window_top #(
    parameter int MAG_W = 8,
    localparam int SW = MAG_W + 1,
    localparam int LW = MAG_W + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp_data,
    input  logic [SW-1:0] ofs_coef,
    input  logic [LW-1:0] lim_a_word,
    input  logic [LW-1:0] lim_b_word,
    input  logic [1:0]    stat_clr,
    output logic [1:0]    stat_hit,
    output logic          irq
);
    import wdg_pkg::*;

    localparam int NLIM = 2;

    wdg_state_t             state_q, state_d;
    logic signed [SW-1:0]   cor_now;
    logic signed [SW-1:0]   cor_q;
    logic [NLIM-1:0]        cmp_fire;
    logic                   cmp_active;
    logic [LW-1:0]          lim_words [NLIM];

    assign lim_words[0] = lim_a_word;
    assign lim_words[1] = lim_b_word;

    wdg_offset_sat #(.W(SW)) u_sat (
        .raw_val (smp_data),
        .ofs_val (ofs_coef),
        .cor_val (cor_now)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cor_q <= '0;
        end else if (smp_valid) begin
            cor_q <= cor_now;
        end
    end

    for (genvar g = 0; g < NLIM; g++) begin : g_lim
        wdg_limit_cmp #(.MAG_W(MAG_W)) u_cmp (
            .cor_smp  (cor_q),
            .lim_word (lim_words[g]),
            .fire     (cmp_fire[g])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (smp_valid) state_d = ST_CMP;
            ST_CMP:  state_d = smp_valid ? ST_CMP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign cmp_active = (state_q == ST_CMP);

    // outputs: sticky status, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_hit <= '0;
        end else begin
            for (int i = 0; i < NLIM; i++) begin
                if (cmp_active && cmp_fire[i]) begin
                    stat_hit[i] <= 1'b1;
                end else if (stat_clr[i]) begin
                    stat_hit[i] <= 1'b0;
                end
            end
        end
    end

    assign irq = |stat_hit;
endmodule

// File: rtl/wdg_window_chk.sv
module wdg_window_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_valid,
    input logic [1:0] stat_clr,
    input logic [1:0] stat_hit,
    input logic [1:0] cmp_fire,
    input logic       cmp_active,
    input logic       irq
);
    // R7
    sticky_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_hit[0] && !stat_clr[0] |=> stat_hit[0]);
    // R7
    sticky_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_hit[1] && !stat_clr[1] |=> stat_hit[1]);
    // R8
    clear_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr[0] && !(cmp_active && cmp_fire[0]) |=> !stat_hit[0]);
    // R8
    clear_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr[1] && !(cmp_active && cmp_fire[1]) |=> !stat_hit[1]);
    // R10
    rise_after_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_hit[0] || !stat_hit[1]) && !cmp_active |=> $stable(stat_hit) || ($countones(stat_hit) < $countones($past(stat_hit))) || stat_hit == '0);
    // R12
    idle_when_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !cmp_active);
    // R9
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_hit == 2'b00 |-> !irq);
endmodule

bind wdg_window_top wdg_window_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .stat_clr   (stat_clr),
    .stat_hit   (stat_hit),
    .cmp_fire   (cmp_fire),
    .cmp_active (cmp_active),
    .irq        (irq)
);

// File: tb/wdg_window_top_bench.sv
module wdg_window_top_bench;
    typedef struct packed {
        logic [8:0] s;
        logic [8:0] o;
        logic [9:0] la;
        logic [9:0] lb;
        logic       ea;
        logic       eb;
    } vec_t;

    localparam int NV = 11;
    // limit word = {dir(1=above), sign(1=neg), mag}
    localparam vec_t VEC [NV] = '{
        '{s: 9'd100,  o: 9'd0,    la: {1'b1,1'b0,8'd50},  lb: {1'b0,1'b1,8'd50},  ea: 1'b1, eb: 1'b0}, // R2
        '{s: -9'sd100,o: 9'd0,    la: {1'b1,1'b0,8'd50},  lb: {1'b0,1'b1,8'd50},  ea: 1'b0, eb: 1'b1}, // R2
        '{s: 9'd50,   o: 9'd0,    la: {1'b1,1'b0,8'd50},  lb: {1'b0,1'b0,8'd50},  ea: 1'b0, eb: 1'b0}, // R3 R4
        '{s: 9'd51,   o: 9'd0,    la: {1'b1,1'b0,8'd50},  lb: {1'b0,1'b0,8'd52},  ea: 1'b1, eb: 1'b1}, // R3 R4
        '{s: 9'd60,   o: 9'd20,   la: {1'b1,1'b0,8'd50},  lb: {1'b0,1'b0,8'd45},  ea: 1'b0, eb: 1'b1}, // R5
        '{s: 9'd200,  o: -9'sd100,la: {1'b1,1'b0,8'd254}, lb: {1'b0,1'b0,8'd255}, ea: 1'b1, eb: 1'b0}, // R6
        '{s: -9'sd200,o: 9'd100,  la: {1'b0,1'b1,8'd255}, lb: {1'b1,1'b1,8'd255}, ea: 1'b1, eb: 1'b0}, // R6
        '{s: 9'd0,    o: 9'd0,    la: {1'b1,1'b1,8'd0},   lb: {1'b0,1'b1,8'd0},   ea: 1'b0, eb: 1'b0}, // R11
        '{s: -9'sd1,  o: 9'd0,    la: {1'b0,1'b1,8'd0},   lb: {1'b1,1'b1,8'd0},   ea: 1'b1, eb: 1'b0}, // R11
        '{s: 9'd5,    o: 9'd0,    la: {1'b1,1'b1,8'd20},  lb: {1'b0,1'b0,8'd20},  ea: 1'b1, eb: 1'b1}, // R13
        '{s: 9'd5,    o: 9'd0,    la: {1'b0,1'b1,8'd20},  lb: {1'b1,1'b0,8'd20},  ea: 1'b0, eb: 1'b0}  // R13
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [8:0] smp_data = '0;
    logic [8:0] ofs_coef = '0;
    logic [9:0] lim_a_word = '0;
    logic [9:0] lim_b_word = '0;
    logic [1:0] stat_clr = '0;
    logic [1:0] stat_hit;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdg_window_top u_wdg_window_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .ofs_coef   (ofs_coef),
        .lim_a_word (lim_a_word),
        .lim_b_word (lim_b_word),
        .stat_clr   (stat_clr),
        .stat_hit   (stat_hit),
        .irq        (irq)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {irq,hit} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk); stat_clr = 2'b11;
        @(negedge clk); stat_clr = 2'b00;
    endtask

    task automatic send(input logic [8:0] s, input logic [8:0] o);
        @(negedge clk); smp_data = s; ofs_coef = o; smp_valid = 1'b1;
        @(negedge clk); smp_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {irq, stat_hit}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {irq, stat_hit}, 3'b000);

        for (int i = 0; i < NV; i++) begin
            clear_all();
            lim_a_word = VEC[i].la;
            lim_b_word = VEC[i].lb;
            send(VEC[i].s, VEC[i].o);
            check($sformatf("R2-vector %0d hits", i), {1'b0, stat_hit}, {1'b0, VEC[i].eb, VEC[i].ea});
            check($sformatf("R9 vector %0d irq", i), {irq, 2'b00}, {VEC[i].ea | VEC[i].eb, 2'b00});
        end

        // R10 latency: status unchanged one edge after acceptance
        clear_all();
        lim_a_word = {1'b1, 1'b0, 8'd10};
        lim_b_word = {1'b1, 1'b0, 8'd200};
        @(negedge clk); smp_data = 9'd50; ofs_coef = '0; smp_valid = 1'b1;
        @(negedge clk); smp_valid = 1'b0;
        check("R10 before update", {irq, stat_hit}, 3'b000);
        @(negedge clk);
        check("R10 after update", {irq, stat_hit}, 3'b101);

        // R7 sticky across a non-firing sample
        send(9'd0, 9'd0);
        check("R7 sticky", {irq, stat_hit}, 3'b101);

        // R8 per-bit clear: set both, clear only B
        lim_b_word = {1'b0, 1'b0, 8'd200};
        send(9'd0, 9'd0);
        lim_a_word = {1'b0, 1'b1, 8'd200};
        lim_b_word = {1'b1, 1'b0, 8'd200};
        @(negedge clk); stat_clr = 2'b10;
        @(negedge clk); stat_clr = 2'b00;
        check("R8 clear B only", {irq, stat_hit}, 3'b101);
        @(negedge clk); stat_clr = 2'b01;
        @(negedge clk); stat_clr = 2'b00;
        check("R8 clear A", {irq, stat_hit}, 3'b000);

        // R8 fire and clear on the same edge: set wins
        lim_a_word = {1'b1, 1'b0, 8'd10};
        @(negedge clk); smp_data = 9'd50; smp_valid = 1'b1;
        @(negedge clk); smp_valid = 1'b0; stat_clr = 2'b01;
        @(negedge clk); stat_clr = 2'b00;
        check("R8 set beats clear", {irq, stat_hit}, 3'b101);

        // R12 data without strobe ignored
        clear_all();
        @(negedge clk); smp_data = 9'd100; smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 no strobe", {irq, stat_hit}, 3'b000);

        // R13 back-to-back samples, second one fires B
        lim_a_word = {1'b1, 1'b0, 8'd200};
        lim_b_word = {1'b0, 1'b1, 8'd100};
        @(negedge clk); smp_data = 9'd0; smp_valid = 1'b1;
        @(negedge clk); smp_data = -9'sd150;
        @(negedge clk); smp_valid = 1'b0;
        @(negedge clk);
        check("R13 back-to-back", {irq, stat_hit}, 3'b110);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule